// File: doc/BRIEF.md
# Segmented Paging Address Translator

This block sits between a CPU core and its memories. It turns a 24-bit logical byte address into a physical address plus a two-bit target type that tells the surrounding logic where the cycle goes: local memory, an expansion-bus memory window, or an expansion-bus I/O window. The translation runs through two maps. A context register picks one of sixteen banks of segment entries. The selected segment entry gives a protection code and a pointer to a group of sixteen page entries. The page entry gives the physical page number, the target type, and two status bits that the hardware maintains.

Only the lowest 2 MiB of logical space is mapped. A supervisor access above that goes straight through as local memory, and a user access there is refused. Each segment's 4-bit protection code is decoded by one of two fixed rights tables, one for user mode and one for supervisor mode. An access that its table does not allow raises a bus error. The CPU loads the context, segment and page entries through a small register port, and it can read them back the same way.

If the expansion bus reports that a cycle was never acknowledged, the block enters a stalled state. From then on every access returns a defer indication until the block is reset. The control is a two-state machine. ST_RUN translates accesses. ST_STALL defers them. The transition ST_RUN to ST_STALL is taken on `bus_nack`, and the only way back from ST_STALL to ST_RUN is reset.

Top module: `segpage_mmu`

## Requirements
- R1: A supervisor access with any of logical bits 23:21 set returns `res_ok` with `res_type` 0 and `res_addr` equal to the logical address.
- R2: A user access with any of logical bits 23:21 set returns `bus_err` and no `res_ok`.
- R3: A context register write (`reg_sel` 0) keeps only `reg_wdata[15:12]`, and a context read returns those four bits with bits 11:0 zero. Segment entries are kept apart per context and are selected by logical bits 20:15.
- R4: A segment write (`reg_sel` 1) stores `reg_wdata[11:0]` in the entry selected by `reg_idx[9:4]` under the current context. A segment read returns the context in bits 15:12 OR'd with the stored 12 bits.
- R5: A page entry is selected by {segment bits 5:0, logical bits 14:11}. The register port (`reg_sel` 2) selects the same entry from `reg_idx[3:0]`. A granted mapped access returns `res_addr` = {0, page bits 11:0, logical bits 10:0} and `res_type` = page bits 13:12.
- R6: A permitted mapped access whose page type is 1 returns `bus_err` instead of `res_ok`.
- R7: In user mode, segment bits 11:8 grant these rights: codes 0 to 5 none, 6 and 7 R, 8 and 9 RW, 10 RX, 11 RWX, 12 and 13 RX, 14 X, 15 RWX. `acc_kind` 0 is a read, 1 a write, 2 a fetch (needs X), and 3 is treated as a read. A denied access returns `bus_err`.
- R8: In supervisor mode the codes grant: 0 none, 1 X, 2 R, 3 RX, 4 RW, 5 RWX, 6 R, 7 RW, 8 R, 9 to 11 RW, 12 RX, 13 to 15 RWX. A denied access returns `bus_err`.
- R9: A permitted mapped write sets page bits 15 (accessed) and 14 (modified). A permitted read or fetch sets only bit 15. A denied access leaves the page entry unchanged.
- R10: `bus_nack` raises `defer` on the next cycle and moves the block to ST_STALL. After that, every access returns `defer` only, with no translation and no page bit update, until reset. The register port keeps working while stalled.
- R11: All results (`res_ok`, `res_type`, `res_addr`, `bus_err`, `defer`, `reg_rdata`) are registered and appear on the cycle after the request. At most one of `res_ok`, `bus_err`, `defer` is high, and all three are low when nothing was requested. All of them are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears the context and the stall |
| acc_valid | input | 1 | Access request, one cycle |
| acc_addr | input | 24 | Logical byte address |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| acc_super | input | 1 | Supervisor mode |
| bus_nack | input | 1 | Expansion-bus cycle not acknowledged |
| reg_valid | input | 1 | Register port request |
| reg_write | input | 1 | 1 write, 0 read |
| reg_sel | input | 2 | 0 context, 1 segment, 2 page, 3 none |
| reg_idx | input | 10 | Logical address bits 20:11 of the register access |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, one cycle after the read |
| res_ok | output | 1 | Access granted pulse |
| res_type | output | 2 | Target type of the granted access |
| res_addr | output | 24 | Physical address of the granted access |
| bus_err | output | 1 | Bus error pulse |
| defer | output | 1 | Defer pulse |

## Verification
Every outcome is due exactly one clock after the request. That covers an access's grant, bus error or defer, a register read's data, and the defer that follows `bus_nack`. The bench drives each request on a falling edge and samples on the next falling edge, so it reads the value that the single rising edge in between has registered. A page-entry status update is written on that same rising edge, so the bench reads the page back only in a later register-port cycle. On every cycle that follows an idle cycle, the bench also checks that all three result strobes are low.

// File: rtl/segpage_pkg.sv
package segpage_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_EXEC  = 2'd2,
        KIND_RSVD  = 2'd3
    } acc_kind_t;

    typedef enum logic [1:0] {
        SEL_CTX  = 2'd0,
        SEL_SEG  = 2'd1,
        SEL_PAGE = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_t;

    typedef enum logic [1:0] {
        TGT_LOCAL  = 2'd0,
        TGT_ABSENT = 2'd1,
        TGT_XMEM   = 2'd2,
        TGT_XIO    = 2'd3
    } tgt_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } rights_t;

    localparam int CODE_W = 4;

endpackage

// File: rtl/segpage_rights.sv
module segpage_rights
    import segpage_pkg::*;
(
    input  logic              super_mode,
    input  logic [CODE_W-1:0] code,
    input  acc_kind_t         kind,
    output logic              allow
);

    rights_t usr, sup, sel;

    always_comb begin
        usr = '0;
        case (code)
            4'd6, 4'd7:   usr = '{rd: 1'b1, wr: 1'b0, ex: 1'b0};
            4'd8, 4'd9:   usr = '{rd: 1'b1, wr: 1'b1, ex: 1'b0};
            4'd10:        usr = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
            4'd11, 4'd15: usr = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
            4'd12, 4'd13: usr = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
            4'd14:        usr = '{rd: 1'b0, wr: 1'b0, ex: 1'b1};
            default:      usr = '0;
        endcase
    end

    always_comb begin
        sup = '0;
        case (code)
            4'd0:               sup = '0;
            4'd1:               sup = '{rd: 1'b0, wr: 1'b0, ex: 1'b1};
            4'd2, 4'd6, 4'd8:   sup = '{rd: 1'b1, wr: 1'b0, ex: 1'b0};
            4'd3, 4'd12:        sup = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
            4'd4, 4'd7, 4'd9,
            4'd10, 4'd11:       sup = '{rd: 1'b1, wr: 1'b1, ex: 1'b0};
            default:            sup = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
        endcase
    end

    always_comb begin
        sel = super_mode ? sup : usr;
        case (kind)
            KIND_WRITE: allow = sel.wr;
            KIND_EXEC:  allow = sel.ex;
            default:    allow = sel.rd;
        endcase
    end

endmodule

// File: rtl/segpage_maps.sv
module segpage_maps #(
    parameter int SEGA_W = 10,
    parameter int SEG_W  = 12,
    parameter int PGA_W  = 10,
    parameter int PTE_W  = 16
) (
    input  logic             clk,
    input  logic [SEGA_W-1:0] seg_ra_acc,
    output logic [SEG_W-1:0]  seg_rd_acc,
    input  logic [SEGA_W-1:0] seg_ra_reg,
    output logic [SEG_W-1:0]  seg_rd_reg,
    input  logic              seg_we,
    input  logic [SEG_W-1:0]  seg_wd,
    input  logic [PGA_W-1:0]  pg_ra_acc,
    output logic [PTE_W-1:0]  pg_rd_acc,
    input  logic [PGA_W-1:0]  pg_ra_reg,
    output logic [PTE_W-1:0]  pg_rd_reg,
    input  logic              pg_we,
    input  logic [PTE_W-1:0]  pg_wd,
    input  logic              flag_en,
    input  logic              flag_mod
);

    localparam int SEG_N   = 1 << SEGA_W;
    localparam int PG_N    = 1 << PGA_W;
    localparam int ACC_BIT = PTE_W - 1;
    localparam int MOD_BIT = PTE_W - 2;

    logic [SEG_W-1:0] seg_mem [SEG_N];
    logic [PTE_W-1:0] pg_mem  [PG_N];

    assign seg_rd_acc = seg_mem[seg_ra_acc];
    assign seg_rd_reg = seg_mem[seg_ra_reg];
    assign pg_rd_acc  = pg_mem[pg_ra_acc];
    assign pg_rd_reg  = pg_mem[pg_ra_reg];

    always_ff @(posedge clk) begin
        if (seg_we)
            seg_mem[seg_ra_reg] <= seg_wd;
    end

    // Register-port writes take priority over status updates.
    always_ff @(posedge clk) begin
        if (pg_we) begin
            pg_mem[pg_ra_reg] <= pg_wd;
        end else if (flag_en) begin
            pg_mem[pg_ra_acc][ACC_BIT] <= 1'b1;
            if (flag_mod)
                pg_mem[pg_ra_acc][MOD_BIT] <= 1'b1;
        end
    end

endmodule

// File: rtl/segpage_ctrl.sv
module segpage_ctrl #(
    parameter int LA_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic            bus_nack,
    input  logic            want_ok,
    input  logic            want_err,
    input  logic            want_flag,
    input  logic [1:0]      want_type,
    input  logic [LA_W-1:0] want_addr,
    output logic            flag_en,
    output logic            res_ok,
    output logic [1:0]      res_type,
    output logic [LA_W-1:0] res_addr,
    output logic            bus_err,
    output logic            defer
);

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_STALL = 1'b1
    } state_t;

    state_t state, state_nxt;
    logic   ok_d, err_d, def_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_RUN;
        else
            state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        ok_d      = 1'b0;
        err_d     = 1'b0;
        def_d     = 1'b0;
        flag_en   = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (bus_nack) begin
                    state_nxt = ST_STALL;
                    def_d     = 1'b1;
                end else if (acc_valid) begin
                    ok_d    = want_ok;
                    err_d   = want_err;
                    flag_en = want_flag;
                end
            end
            ST_STALL: begin
                def_d = acc_valid;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_ok   <= 1'b0;
            res_type <= '0;
            res_addr <= '0;
            bus_err  <= 1'b0;
            defer    <= 1'b0;
        end else begin
            res_ok   <= ok_d;
            res_type <= ok_d ? want_type : '0;
            res_addr <= ok_d ? want_addr : '0;
            bus_err  <= err_d;
            defer    <= def_d;
        end
    end

endmodule

// File: rtl/segpage_mmu.sv
module segpage_mmu
    import segpage_pkg::*;
#(
    parameter int LA_W   = 24,
    parameter int CTX_W  = 4,
    parameter int SEGI_W = 6,
    parameter int PTR_W  = 6,
    parameter int PGI_W  = 4,
    parameter int OFS_W  = 11,
    parameter int PFN_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_valid,
    input  logic [LA_W-1:0]         acc_addr,
    input  logic [1:0]              acc_kind,
    input  logic                    acc_super,
    input  logic                    bus_nack,
    input  logic                    reg_valid,
    input  logic                    reg_write,
    input  logic [1:0]              reg_sel,
    input  logic [SEGI_W+PGI_W-1:0] reg_idx,
    input  logic [DATA_W-1:0]       reg_wdata,
    output logic [DATA_W-1:0]       reg_rdata,
    output logic                    res_ok,
    output logic [1:0]              res_type,
    output logic [LA_W-1:0]         res_addr,
    output logic                    bus_err,
    output logic                    defer
);

    localparam int SEG_W    = DATA_W - CTX_W;
    localparam int CODE_LSB = SEG_W - CODE_W;
    localparam int MAP_TOP  = OFS_W + PGI_W + SEGI_W;
    localparam int SEGA_W   = CTX_W + SEGI_W;
    localparam int PGA_W    = PTR_W + PGI_W;
    localparam int PA_PAD   = LA_W - PFN_W - OFS_W;
    localparam int TYP_LSB  = PFN_W;

    logic [CTX_W-1:0]  ctx_q;
    logic [SEG_W-1:0]  seg_acc, seg_reg;
    logic [DATA_W-1:0] pte_acc, pte_reg;
    logic [SEGA_W-1:0] seg_ra_acc, seg_ra_reg;
    logic [PGA_W-1:0]  pg_ra_acc, pg_ra_reg;
    logic              mapped, allow, flag_en;
    logic              want_ok, want_err, want_flag;
    logic [1:0]        want_type;
    logic [LA_W-1:0]   want_addr;
    logic              reg_wr, reg_rd;
    reg_sel_t          sel;
    acc_kind_t         kind;
    tgt_t              pte_tgt;

    assign sel    = reg_sel_t'(reg_sel);
    assign kind   = acc_kind_t'(acc_kind);
    assign reg_wr = reg_valid && reg_write;
    assign reg_rd = reg_valid && !reg_write;

    // Context register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctx_q <= '0;
        else if (reg_wr && sel == SEL_CTX)
            ctx_q <= reg_wdata[DATA_W-1 -: CTX_W];
    end

    // Map indices, access side and register side
    assign mapped     = (acc_addr[LA_W-1:MAP_TOP] == '0);
    assign seg_ra_acc = {ctx_q, acc_addr[MAP_TOP-1 -: SEGI_W]};
    assign pg_ra_acc  = {seg_acc[PTR_W-1:0], acc_addr[OFS_W+PGI_W-1 -: PGI_W]};
    assign seg_ra_reg = {ctx_q, reg_idx[SEGI_W+PGI_W-1 -: SEGI_W]};
    assign pg_ra_reg  = {seg_reg[PTR_W-1:0], reg_idx[PGI_W-1:0]};

    segpage_maps #(
        .SEGA_W (SEGA_W),
        .SEG_W  (SEG_W),
        .PGA_W  (PGA_W),
        .PTE_W  (DATA_W)
    ) i_maps (
        .clk        (clk),
        .seg_ra_acc (seg_ra_acc),
        .seg_rd_acc (seg_acc),
        .seg_ra_reg (seg_ra_reg),
        .seg_rd_reg (seg_reg),
        .seg_we     (reg_wr && sel == SEL_SEG),
        .seg_wd     (reg_wdata[SEG_W-1:0]),
        .pg_ra_acc  (pg_ra_acc),
        .pg_rd_acc  (pte_acc),
        .pg_ra_reg  (pg_ra_reg),
        .pg_rd_reg  (pte_reg),
        .pg_we      (reg_wr && sel == SEL_PAGE),
        .pg_wd      (reg_wdata),
        .flag_en    (flag_en),
        .flag_mod   (kind == KIND_WRITE)
    );

    segpage_rights i_rights (
        .super_mode (acc_super),
        .code       (seg_acc[CODE_LSB +: CODE_W]),
        .kind       (kind),
        .allow      (allow)
    );

    assign pte_tgt = tgt_t'(pte_acc[TYP_LSB +: 2]);

    // Outcome of a translation, before the control decides whether it counts
    always_comb begin
        want_ok   = 1'b0;
        want_err  = 1'b0;
        want_flag = 1'b0;
        want_type = TGT_LOCAL;
        want_addr = '0;
        if (mapped) begin
            if (allow) begin
                want_flag = 1'b1;
                if (pte_tgt == TGT_ABSENT) begin
                    want_err = 1'b1;
                end else begin
                    want_ok   = 1'b1;
                    want_type = pte_tgt;
                    want_addr = {{PA_PAD{1'b0}}, pte_acc[PFN_W-1:0], acc_addr[OFS_W-1:0]};
                end
            end else begin
                want_err = 1'b1;
            end
        end else if (acc_super) begin
            want_ok   = 1'b1;
            want_addr = acc_addr;
        end else begin
            want_err = 1'b1;
        end
    end

    segpage_ctrl #(
        .LA_W (LA_W)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .bus_nack  (bus_nack),
        .want_ok   (want_ok),
        .want_err  (want_err),
        .want_flag (want_flag),
        .want_type (want_type),
        .want_addr (want_addr),
        .flag_en   (flag_en),
        .res_ok    (res_ok),
        .res_type  (res_type),
        .res_addr  (res_addr),
        .bus_err   (bus_err),
        .defer     (defer)
    );

    // Register port read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (sel)
                SEL_CTX:  reg_rdata <= {ctx_q, {SEG_W{1'b0}}};
                SEL_SEG:  reg_rdata <= {ctx_q, seg_reg};
                SEL_PAGE: reg_rdata <= pte_reg;
                default:  reg_rdata <= '0;
            endcase
        end
    end

    logic unused_bits;
    assign unused_bits = ^{seg_acc[CODE_LSB-1:PTR_W], pte_acc[DATA_W-1:TYP_LSB+2]};

endmodule

// File: rtl/segpage_mmu_chk.sv
module segpage_mmu_chk #(
    parameter int LA_W    = 24,
    parameter int MAP_TOP = 21
) (
    input logic            clk,
    input logic            rst_n,
    input logic            acc_valid,
    input logic [LA_W-1:0] acc_addr,
    input logic            acc_super,
    input logic            bus_nack,
    input logic            res_ok,
    input logic [1:0]      res_type,
    input logic [LA_W-1:0] res_addr,
    input logic            bus_err,
    input logic            defer
);

    logic stuck;
    logic high_space;

    assign high_space = (acc_addr[LA_W-1:MAP_TOP] != '0);

    always_ff @(posedge clk) begin
        if (!rst_n)
            stuck <= 1'b0;
        else if (bus_nack)
            stuck <= 1'b1;
    end

    assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({res_ok, bus_err, defer}) <= 1);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && !bus_nack) |=> (!res_ok && !bus_err && !defer));

    assert_nack_defer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_nack |=> defer);

    assert_stall_defer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && stuck) |=> (defer && !res_ok && !bus_err));

    assert_user_high_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_super && high_space && !stuck && !bus_nack) |=> bus_err);

    assert_super_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_super && high_space && !stuck && !bus_nack)
        |=> (res_ok && res_type == 2'd0 && res_addr == $past(acc_addr)));

endmodule

bind segpage_mmu segpage_mmu_chk #(
    .LA_W    (LA_W),
    .MAP_TOP (OFS_W + PGI_W + SEGI_W)
) i_segpage_mmu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .acc_super (acc_super),
    .bus_nack  (bus_nack),
    .res_ok    (res_ok),
    .res_type  (res_type),
    .res_addr  (res_addr),
    .bus_err   (bus_err),
    .defer     (defer)
);

// File: tb/test_segpage_mmu.sv
`timescale 1ns/1ps
module test_segpage_mmu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [23:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic        acc_super = 1'b0;
    logic        bus_nack = 1'b0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [9:0]  reg_idx = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        res_ok;
    logic [1:0]  res_type;
    logic [23:0] res_addr;
    logic        bus_err;
    logic        defer;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    segpage_mmu i_segpage_mmu (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_kind(acc_kind), .acc_super(acc_super), .bus_nack(bus_nack),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_sel(reg_sel),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .res_ok(res_ok), .res_type(res_type), .res_addr(res_addr),
        .bus_err(bus_err), .defer(defer)
    );

    // Behavioural reference state
    int  seg_m[int];
    int  page_m[int];
    int  ctx_m = 0;
    bit  stalled_m = 0;
    string user_tab[16] = '{"", "", "", "", "", "", "R", "R",
                            "RW", "RW", "RX", "RWX", "RX", "RX", "X", "RWX"};
    string sup_tab[16]  = '{"", "X", "R", "RX", "RW", "RWX", "R", "RW",
                            "R", "RW", "RW", "RW", "RX", "RWX", "RWX", "RWX"};

    function automatic bit has_right(string s, byte c);
        for (int i = 0; i < s.len(); i++)
            if (s[i] == c) return 1;
        return 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Cycle-by-cycle idle check: no request in the previous cycle means no strobe.
    logic prev_busy = 1'b1;
    always @(posedge clk) prev_busy <= acc_valid | bus_nack | !rst_n;
    always @(negedge clk) begin
        if (rst_n && !prev_busy && !finished) begin
            n_chk++;
            if (res_ok || bus_err || defer) begin
                n_err++;
                $display("FAIL R11: idle strobes actual=%b%b%b expected=000", res_ok, bus_err, defer);
            end
        end
    end

    task automatic model(int addr, int kind, bit sup,
                         output int e_ok, output int e_err, output int e_def,
                         output int e_typ, output int e_pa);
        int seg, code, pi, pte;
        string tab;
        byte need;
        e_ok = 0; e_err = 0; e_def = 0; e_typ = 0; e_pa = 0;
        if (stalled_m) begin
            e_def = 1;
            return;
        end
        if ((addr >> 21) != 0) begin
            if (sup) begin e_ok = 1; e_pa = addr; end
            else e_err = 1;
            return;
        end
        seg  = seg_m.exists(ctx_m * 64 + ((addr >> 15) & 63)) ? seg_m[ctx_m * 64 + ((addr >> 15) & 63)] : 0;
        code = (seg >> 8) & 15;
        tab  = sup ? sup_tab[code] : user_tab[code];
        need = (kind == 1) ? "W" : (kind == 2) ? "X" : "R";
        if (!has_right(tab, need)) begin
            e_err = 1;
            return;
        end
        pi  = ((seg & 63) * 16) + ((addr >> 11) & 15);
        pte = page_m.exists(pi) ? page_m[pi] : 0;
        page_m[pi] = pte | 'h8000 | ((kind == 1) ? 'h4000 : 0);
        e_typ = (pte >> 12) & 3;
        if (e_typ == 1) e_err = 1;
        else begin
            e_ok = 1;
            e_pa = ((pte & 'hfff) << 11) | (addr & 'h7ff);
        end
    endtask

    task automatic do_acc(int addr, int kind, bit sup, string req);
        int e_ok, e_err, e_def, e_typ, e_pa;
        model(addr, kind, sup, e_ok, e_err, e_def, e_typ, e_pa);
        @(negedge clk);
        acc_valid = 1; acc_addr = addr[23:0]; acc_kind = kind[1:0]; acc_super = sup;
        @(negedge clk);
        acc_valid = 0;
        chk({req, " ok"}, int'(res_ok), e_ok);
        chk({req, " bus_err"}, int'(bus_err), e_err);
        chk({req, " defer"}, int'(defer), e_def);
        if (e_ok) begin
            chk({req, " type"}, int'(res_type), e_typ);
            chk({req, " paddr"}, int'(res_addr), e_pa);
        end
    endtask

    task automatic reg_wr(int sel, int idx, int data);
        if (sel == 0) ctx_m = (data >> 12) & 15;
        if (sel == 1) seg_m[ctx_m * 64 + ((idx >> 4) & 63)] = data & 'hfff;
        if (sel == 2) begin
            int s;
            s = seg_m.exists(ctx_m * 64 + ((idx >> 4) & 63)) ? seg_m[ctx_m * 64 + ((idx >> 4) & 63)] : 0;
            page_m[(s & 63) * 16 + (idx & 15)] = data & 'hffff;
        end
        @(negedge clk);
        reg_valid = 1; reg_write = 1; reg_sel = sel[1:0]; reg_idx = idx[9:0]; reg_wdata = data[15:0];
        @(negedge clk);
        reg_valid = 0; reg_write = 0;
    endtask

    task automatic reg_rd(int sel, int idx, int exp, string req);
        @(negedge clk);
        reg_valid = 1; reg_write = 0; reg_sel = sel[1:0]; reg_idx = idx[9:0];
        @(negedge clk);
        reg_valid = 0;
        chk(req, int'(reg_rdata), exp);
    endtask

    function automatic int page_of(int idx);
        int s;
        s = seg_m.exists(ctx_m * 64 + ((idx >> 4) & 63)) ? seg_m[ctx_m * 64 + ((idx >> 4) & 63)] : 0;
        return page_m[(s & 63) * 16 + (idx & 15)];
    endfunction

    task automatic show_summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #600000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        show_summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        chk("R11 reset res_ok", int'(res_ok), 0);
        chk("R11 reset bus_err", int'(bus_err), 0);
        chk("R11 reset defer", int'(defer), 0);
        chk("R11 reset rdata", int'(reg_rdata), 0);
        rst_n = 1;
        reg_rd(0, 0, 'h0000, "R3 context after reset");

        // R3: context keeps only the top four bits
        reg_wr(0, 0, 'hA5C3);
        reg_rd(0, 0, 'hA000, "R3 context readback");
        // R4: segment store and readback
        reg_wr(1, 5 << 4, 'hF3A5);
        reg_rd(1, 5 << 4, 'hA3A5, "R4 segment readback");

        // R1/R2: unmapped space
        do_acc('hE01234, 0, 1, "R1 super high read");
        do_acc('h600010, 1, 1, "R1 super high write");
        do_acc('hE01234, 0, 0, "R2 user high read");
        do_acc('h200000, 2, 0, "R2 user high fetch");

        // R7/R8/R9: full sweep of both rights tables
        reg_wr(0, 0, 'h1000);
        for (int sup = 0; sup < 2; sup++) begin
            for (int code = 0; code < 16; code++) begin
                for (int kind = 0; kind < 4; kind++) begin
                    reg_wr(1, 0, (code << 8) | 7);
                    reg_wr(2, 0, 'h0123);
                    do_acc('h0004A, kind, sup[0], sup ? "R8 rights" : "R7 rights");
                    reg_rd(2, 0, page_of(0), "R9 status bits");
                end
            end
        end

        // R5/R6: page selection, address formation and target types
        reg_wr(1, 3 << 4, (15 << 8) | 'h2A);
        reg_wr(2, (3 << 4) | 9, 'h2ABC);
        reg_wr(2, (3 << 4) | 10, 'h3456);
        reg_wr(2, (3 << 4) | 11, 'h1777);
        do_acc((3 << 15) | (9 << 11) | 'h5F2, 0, 0, "R5 expansion memory");
        do_acc((3 << 15) | (10 << 11) | 'h001, 2, 0, "R5 expansion io");
        do_acc((3 << 15) | (11 << 11) | 'h100, 0, 0, "R6 absent page");
        do_acc((3 << 15) | (9 << 11) | 'h7FE, 1, 1, "R5 super write");
        reg_rd(2, (3 << 4) | 9, page_of((3 << 4) | 9), "R9 write sets both");
        reg_rd(2, (3 << 4) | 10, page_of((3 << 4) | 10), "R9 fetch sets accessed");

        // R3: a different context sees its own segment entry
        reg_wr(0, 0, 'h2000);
        reg_wr(1, 3 << 4, (0 << 8) | 'h2A);
        do_acc((3 << 15) | (9 << 11), 0, 0, "R3 other context denied");
        reg_wr(0, 0, 'h1000);
        reg_rd(1, 3 << 4, 'h1F2A, "R3 context one entry kept");
        do_acc((3 << 15) | (9 << 11), 0, 0, "R3 context one granted");

        // R10: stall after an unacknowledged bus cycle
        reg_wr(2, (3 << 4) | 12, 'h0055);
        @(negedge clk);
        bus_nack = 1;
        @(negedge clk);
        bus_nack = 0;
        stalled_m = 1;
        chk("R10 nack defer", int'(defer), 1);
        chk("R10 nack no ok", int'(res_ok), 0);
        do_acc((3 << 15) | (12 << 11), 1, 1, "R10 stalled write");
        do_acc('hE00000, 0, 1, "R10 stalled high");
        reg_rd(2, (3 << 4) | 12, 'h0055, "R10 no status update");
        repeat (3) @(negedge clk);
        do_acc('h000000, 0, 0, "R10 still stalled");

        // R10: reset leaves the stall
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        stalled_m = 0;
        ctx_m = 0;
        do_acc('hE00000, 0, 1, "R10 after reset");
        reg_rd(0, 0, 'h0000, "R3 context cleared");

        repeat (2) @(negedge clk);
        show_summary();
    end

endmodule